// File: doc/BRIEF.md
# Calibrated Bank Temperature Converter

This block turns raw sensor codes from the sensing points of one thermal bank into a single bank temperature in millidegrees Celsius. A caller presents the raw codes, a bank selector and three fuse words, then pulses `start_i`. The block unpacks the calibration fields from the fuse words. It substitutes fixed defaults when the fuse data is not marked valid.

The block then derives a per-job scale factor through two successive integer divisions. For each sensing point that the selected bank uses, it converts the code through a signed 32-bit fixed-point formula. Any implausibly hot reading is discarded to zero. The bank result is the largest converted value.

The arithmetic is done by one iterative divider and one iterative shift-add multiplier, each taking 32 cycles per operation. A job therefore takes a few hundred cycles. `busy_o` is high while a job runs. `done_o` pulses once with the result on `temp_o`, and the result is held there until the next job completes.

Top module: `tcv_bank_max`

## Requirements
- R1: Only the low 12 bits of each 16-bit raw code are used; bits 15:12 have no effect on the result.
- R2: Each point converts as: take 1627604160, divide by (165 + slope offset), divide by (10000 + gain error), multiply by (code − sensor reference − 3350), arithmetic shift right by 3, and subtract that from reference temperature × 500. All steps use signed 32-bit arithmetic with truncating division.
- R3: Fuse fields (word.bits) are as follows:
  - gain error = fuse1[31:22]
  - slope offset = fuse0[31:26]
  - reference temperature = fuse0[6:1]
  - sensor references: sensor A = fuse0[25:17], sensor B = fuse0[16:8], sensor C = fuse1[8:0], sensor D = fuse2[31:23], sensor E = fuse2[22:14]
- R4: When fuse0[0] is 0, the block uses gain 0, slope 0, reference temperature 50 and reference 260 for every sensor, whatever the other fuse bits hold.
- R5: A converted value above 200000 is replaced by 0 before the maximum is taken.
- R6: `bank_i` selects the sensor for each sensing point (point p reads raw_i[16p+15:16p]):
  - 0: points 0,1 = sensors B,C
  - 1: points 0,1 = sensors B,D
  - 2: points 0,1,2 = sensors A,B,E
  - 3: point 0 = sensor B

  The result is the signed maximum over those points, starting from −2^31. Raw codes at unused points have no effect.
- R7: `done_o` is high for exactly one cycle per accepted job. `temp_o` changes only in a cycle where `done_o` is high and holds its value otherwise.
- R8: All inputs are captured in the cycle `start_i` is accepted. A `start_i` while `busy_o` is high is ignored and produces no extra result. Input changes during a job have no effect on it.
- R9: A `start_i` in the cycle where `done_o` is high is accepted as a new job.
- R10: After reset, `done_o`, `busy_o` and `temp_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch a job when not busy |
| bank_i | input | 2 | Bank configuration selector |
| raw_i | input | 64 | Four 16-bit raw codes, point p at bits 16p+15:16p |
| fuse0_i | input | 32 | Fuse word 0 |
| fuse1_i | input | 32 | Fuse word 1 |
| fuse2_i | input | 32 | Fuse word 2 |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle result strobe |
| temp_o | output | 32 | Bank temperature, signed millidegrees |

## Verification
Two events can fall in one cycle: the completion of one job (`done_o` with its result) and the acceptance of the next `start_i`. The bench provokes this by waiting for `done_o` at a falling edge and raising `start_i` in that same cycle with new inputs. The behavioural model then expects both the old result in that cycle and a second result computed from the new inputs. A stray `start_i` raised mid-job, and inputs scrambled right after launch, must produce neither an extra strobe nor any change to the pending result.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
  localparam int DW     = 32;
  localparam int CODE_W = 12;
  localparam int GE_W   = 10;
  localparam int SL_W   = 6;
  localparam int DG_W   = 6;
  localparam int VTS_W  = 9;
  localparam int N_SENS = 5;

  localparam logic [DW-1:0]        NUM0       = 32'd1627604160;
  localparam logic [DW-1:0]        SLOPE_BASE = 32'd165;
  localparam logic [DW-1:0]        GAIN_BASE  = 32'd10000;
  localparam logic [DW-1:0]        DEGC_SCALE = 32'd500;
  localparam logic [DW-1:0]        VOFF       = 32'd3350;
  localparam logic signed [DW-1:0] HOT_LIM    = 32'sd200000;
  localparam logic signed [DW-1:0] MIN_T      = 32'sh8000_0000;

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2, S_MUL} tcv_state_t;

  typedef struct packed {
    logic [GE_W-1:0]               gain;
    logic [SL_W-1:0]               slope;
    logic [DG_W-1:0]               degc;
    logic [N_SENS-1:0][VTS_W-1:0]  vts;
  } tcv_cal_t;

  // number of sensing points used by a bank
  function automatic logic [2:0] pt_count(input logic [1:0] b);
    case (b)
      2'd0, 2'd1: pt_count = 3'd2;
      2'd2:       pt_count = 3'd3;
      default:    pt_count = 3'd1;
    endcase
  endfunction

  // zero-based sensor id feeding point p of bank b
  function automatic logic [2:0] pt_sensor(input logic [1:0] b, input logic [1:0] p);
    pt_sensor = 3'd1;
    case (b)
      2'd0: if (p == 2'd1) pt_sensor = 3'd2;
      2'd1: if (p == 2'd1) pt_sensor = 3'd3;
      2'd2: pt_sensor = (p == 2'd0) ? 3'd0 : (p == 2'd1) ? 3'd1 : 3'd4;
      default: pt_sensor = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/tcv_fuse.sv
module tcv_fuse import tcv_pkg::*; #(
  parameter int DEF_GAIN  = 0,
  parameter int DEF_SLOPE = 0,
  parameter int DEF_DEGC  = 50,
  parameter int DEF_VTS   = 260
) (
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  input  logic [31:0] w2_i,
  output tcv_cal_t    cal_o
);
  logic fuse_unused;
  assign fuse_unused = ^{w1_i[21:9], w2_i[13:0]};

  always_comb begin
    if (w0_i[0]) begin
      cal_o.gain   = w1_i[31:22];
      cal_o.slope  = w0_i[31:26];
      cal_o.degc   = w0_i[6:1];
      cal_o.vts[0] = w0_i[25:17];
      cal_o.vts[1] = w0_i[16:8];
      cal_o.vts[2] = w1_i[8:0];
      cal_o.vts[3] = w2_i[31:23];
      cal_o.vts[4] = w2_i[22:14];
    end else begin
      cal_o.gain  = GE_W'(DEF_GAIN);
      cal_o.slope = SL_W'(DEF_SLOPE);
      cal_o.degc  = DG_W'(DEF_DEGC);
      for (int s = 0; s < N_SENS; s++) cal_o.vts[s] = VTS_W'(DEF_VTS);
    end
  end
endmodule

// File: rtl/tcv_div.sv
module tcv_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, den_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;
  logic [W:0]    shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = ~trial[W];
    rem_d   = rem_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      rem_d = '0;
      quo_d = num_i;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      rem_d = fits ? trial[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      if (start_i) den_q <= den_i;
      done_q <= !start_i && (cnt_q == CW'(1));
    end
  end

  assign quot_o = quo_q;
  assign done_o = done_q;

  // R2
  div_launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt_q == '0));
endmodule

// File: rtl/tcv_mul.sv
module tcv_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  a_q, a_d, b_q, b_d, acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (start_i) begin
      a_d   = a_i;
      b_d   = b_i;
      acc_d = '0;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      acc_d = b_q[0] ? acc_q + a_q : acc_q;
      a_d   = {a_q[W-2:0], 1'b0};
      b_d   = {1'b0, b_q[W-1:1]};
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      done_q <= !start_i && (cnt_q == CW'(1));
    end
  end

  assign prod_o = acc_q;
  assign done_o = done_q;

  // R2
  mul_launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt_q == '0));
endmodule

// File: rtl/tcv_bank_max.sv
module tcv_bank_max import tcv_pkg::*; #(
  parameter int RAW_W     = 16,
  parameter int N_PT      = 4,
  parameter int DEF_GAIN  = 0,
  parameter int DEF_SLOPE = 0,
  parameter int DEF_DEGC  = 50,
  parameter int DEF_VTS   = 260
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [1:0]            bank_i,
  input  logic [N_PT*RAW_W-1:0] raw_i,
  input  logic [31:0]           fuse0_i,
  input  logic [31:0]           fuse1_i,
  input  logic [31:0]           fuse2_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [31:0]           temp_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  tcv_cal_t cal_now, cal_q;
  tcv_fuse #(.DEF_GAIN(DEF_GAIN), .DEF_SLOPE(DEF_SLOPE),
             .DEF_DEGC(DEF_DEGC), .DEF_VTS(DEF_VTS)) u_fuse (
    .w0_i(fuse0_i), .w1_i(fuse1_i), .w2_i(fuse2_i), .cal_o(cal_now));

  // R1: codes are cut to their low bits at capture
  logic [N_PT-1:0][CODE_W-1:0] raw_now, raw_q;
  logic [N_PT-1:0]             raw_unused;
  for (genvar p = 0; p < N_PT; p++) begin : g_code
    assign raw_now[p]    = raw_i[p*RAW_W +: CODE_W];
    assign raw_unused[p] = ^raw_i[p*RAW_W+CODE_W +: RAW_W-CODE_W];
  end

  tcv_state_t          state_q, state_d;
  logic [1:0]          bank_q, pt_q, pt_d, launch_pt;
  logic [DW-1:0]       k_q, div_a, div_b, div_q, mul_a, mul_b, mul_p;
  logic signed [DW-1:0] max_q, max_d, res_q;
  logic signed [DW-1:0] prod_sh, base, tval, tclip, best;
  logic                done_q, div_go, div_done, mul_go, mul_done;
  logic                cap_en, k_en, pt_en, max_en, res_en, last;

  tcv_div #(.W(DW)) u_div (.clk(clk), .rst_n(rst_sn), .start_i(div_go),
    .num_i(div_a), .den_i(div_b), .quot_o(div_q), .done_o(div_done));

  tcv_mul #(.W(DW)) u_mul (.clk(clk), .rst_n(rst_sn), .start_i(mul_go),
    .a_i(mul_a), .b_i(mul_b), .prod_o(mul_p), .done_o(mul_done));

  // operands for the next multiply
  always_comb begin
    launch_pt = (state_q == S_MUL) ? pt_q + 2'd1 : 2'd0;
    mul_a = DW'(raw_q[launch_pt]) - DW'(cal_q.vts[pt_sensor(bank_q, launch_pt)]) - VOFF;
    mul_b = (state_q == S_DIV2) ? div_q : k_q;
  end

  // finish a point: shift, offset, hot reject, running max
  always_comb begin
    prod_sh = $signed(mul_p) >>> 3;
    base    = $signed(DW'(cal_q.degc) * DEGC_SCALE);
    tval    = base - prod_sh;
    tclip   = (tval > HOT_LIM) ? '0 : tval;
    best    = (tclip > max_q) ? tclip : max_q;
    last    = ({1'b0, pt_q} == (pt_count(bank_q) - 3'd1));
  end

  always_comb begin
    state_d = state_q;
    div_go = 1'b0; div_a = '0; div_b = '0; mul_go = 1'b0;
    cap_en = 1'b0; k_en = 1'b0; pt_en = 1'b0; pt_d = pt_q;
    max_en = 1'b0; max_d = max_q; res_en = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        cap_en = 1'b1; div_go = 1'b1;
        div_a = NUM0; div_b = SLOPE_BASE + DW'(cal_now.slope);
        state_d = S_DIV1;
      end
      S_DIV1: if (div_done) begin
        div_go = 1'b1; div_a = div_q; div_b = GAIN_BASE + DW'(cal_q.gain);
        state_d = S_DIV2;
      end
      S_DIV2: if (div_done) begin
        k_en = 1'b1; mul_go = 1'b1; pt_en = 1'b1; pt_d = '0;
        max_en = 1'b1; max_d = MIN_T;
        state_d = S_MUL;
      end
      S_MUL: if (mul_done) begin
        max_en = 1'b1; max_d = best;
        if (last) begin
          res_en = 1'b1; state_d = S_IDLE;
        end else begin
          pt_en = 1'b1; pt_d = pt_q + 2'd1; mul_go = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= S_IDLE;
      bank_q  <= '0;
      raw_q   <= '0;
      cal_q   <= '0;
      k_q     <= '0;
      pt_q    <= '0;
      max_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        bank_q <= bank_i;
        raw_q  <= raw_now;
        cal_q  <= cal_now;
      end
      if (k_en)   k_q   <= div_q;
      if (pt_en)  pt_q  <= pt_d;
      if (max_en) max_q <= max_d;
      if (res_en) res_q <= max_d;
      done_q <= res_en;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign temp_o = res_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_o |-> $stable(temp_o));
  // R5
  hot_cap_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> ($signed(temp_o) <= HOT_LIM));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_o && start_i) |=> ($stable(bank_q) && $stable(raw_q)));
  // R9
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && start_i) |=> busy_o);
  // R6
  mul_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mul_done |-> (state_q == S_MUL));
endmodule

// File: tb/tb_tcv_bank_max.sv
module tb_tcv_bank_max;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  bank_i;
  logic [63:0] raw_i;
  logic [31:0] fuse0_i, fuse1_i, fuse2_i;
  logic        busy_o, done_o;
  logic [31:0] temp_o;

  always #2 clk = ~clk;

  tcv_bank_max dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .bank_i(bank_i),
    .raw_i(raw_i), .fuse0_i(fuse0_i), .fuse1_i(fuse1_i), .fuse2_i(fuse2_i),
    .busy_o(busy_o), .done_o(done_o), .temp_o(temp_o));

  int    checks = 0, failures = 0, launched = 0, seen = 0;
  int    exp_q[$];
  string tag_q[$];
  int    last_res = 0;
  bit    live = 0;
  bit    ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int conv(int code, int vref, int ge, int sl, int dg);
    int t;
    t = 1627604160;
    t = t / (165 + sl);
    t = t / (10000 + ge);
    t = t * ((code & 4095) - vref - 3350);
    t = t >>> 3;
    return dg * 500 - t;
  endfunction

  function automatic int model(int bank, logic [63:0] raws, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    int ge, sl, dg, m, v, n;
    int vr[5];
    int sens[3];
    if (a[0]) begin
      ge = int'(b[31:22]); sl = int'(a[31:26]); dg = int'(a[6:1]);
      vr[0] = int'(a[25:17]); vr[1] = int'(a[16:8]); vr[2] = int'(b[8:0]);
      vr[3] = int'(c[31:23]); vr[4] = int'(c[22:14]);
    end else begin
      ge = 0; sl = 0; dg = 50;
      foreach (vr[i]) vr[i] = 260;
    end
    if (bank == 0)      begin n = 2; sens = '{1, 2, 0}; end
    else if (bank == 1) begin n = 2; sens = '{1, 3, 0}; end
    else if (bank == 2) begin n = 3; sens = '{0, 1, 4}; end
    else                begin n = 1; sens = '{1, 0, 0}; end
    m = 32'sh8000_0000;
    for (int p = 0; p < n; p++) begin
      v = conv(int'(raws[p*16 +: 16]), vr[sens[p]], ge, sl, dg);
      if (v > 200000) v = 0;
      if (v > m) m = v;
    end
    return m;
  endfunction

  // monitor, every clock
  always @(negedge clk) begin
    if (live) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected done", int'(temp_o), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'(temp_o) == e, t, int'(temp_o), e);
          last_res = int'(temp_o);
          seen++;
        end
      end else begin
        chk(int'(temp_o) == last_res, "R7 hold", int'(temp_o), last_res);
      end
    end
  end

  task automatic launch(input int bank, input logic [63:0] raws, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input string tag,
                        input bit at_done);
    @(negedge clk);
    if (at_done) while (!done_o) @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1; bank_i = 2'(bank); raw_i = raws;
    fuse0_i = a; fuse1_i = b; fuse2_i = c;
    exp_q.push_back(model(bank, raws, a, b, c));
    tag_q.push_back(tag);
    launched++;
    @(negedge clk);
    start_i = 1'b0;
    raw_i   = {$urandom, $urandom};
    bank_i  = 2'($urandom);
    fuse0_i = $urandom; fuse1_i = $urandom; fuse2_i = $urandom;
  endtask

  function automatic logic [31:0] mk0(int sl, int va, int vb, int dg, bit ok);
    return (32'(sl) << 26) | (32'(va) << 17) | (32'(vb) << 8) | (32'(dg) << 1) | 32'(ok);
  endfunction

  function automatic logic [63:0] r4(int p0, int p1, int p2, int p3);
    return {16'(p3), 16'(p2), 16'(p1), 16'(p0)};
  endfunction

  initial begin
    logic [31:0] f0, f1, f2;
    rst_n = 1'b0; start_i = 1'b0; bank_i = '0; raw_i = '0;
    fuse0_i = '0; fuse1_i = '0; fuse2_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R10 done", int'(done_o), 0);
    chk(busy_o == 1'b0, "R10 busy", int'(busy_o), 0);
    chk(temp_o == '0, "R10 temp", int'(temp_o), 0);
    live = 1;

    f0 = mk0(20, 300, 280, 40, 1'b1);
    f1 = (32'd600 << 22) | 32'd250;
    f2 = (32'd270 << 23) | (32'd310 << 14);
    // R2 R3 R6: every bank, junk in unused points
    launch(0, r4(2600, 2500, 1111, 999), f0, f1, f2, "R6 bank0", 0);
    launch(1, r4(2400, 2700, 77, 4000), f0, f1, f2, "R6 bank1", 0);
    launch(2, r4(2550, 2800, 2300, 5), f0, f1, f2, "R6 bank2", 0);
    launch(3, r4(2650, 0, 0, 0), f0, f1, f2, "R3 bank3", 0);
    launch(2, r4(3500, 3600, 3700, 0), f0, f1, f2, "R2 cold", 0);
    // R1: upper nibble set
    launch(0, r4(16'hF000 | 2600, 16'hA000 | 2500, 0, 0), f0, f1, f2, "R1 mask", 0);
    // R5: one point very hot, other cold
    launch(1, r4(0, 3900, 0, 0), f0, f1, f2, "R5 hot reject", 0);
    launch(3, r4(0, 0, 0, 0), f0, f1, f2, "R5 all hot", 0);
    // R4: invalid fuse with junk fields
    launch(2, r4(2500, 2600, 2700, 0), 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 defaults", 0);
    // R8: stray start while busy
    launch(0, r4(2700, 2200, 0, 0), f0, f1, f2, "R8 captured", 0);
    repeat (10) @(negedge clk);
    start_i = 1'b1; bank_i = 2'd2; raw_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    // R9: launch exactly in the done cycle
    launch(1, r4(2100, 2900, 0, 0), f0, f1, f2, "R9 back-to-back", 1);
    launch(2, r4(2300, 2333, 2444, 0), 32'h1234_5677, f1, f2, "R9 second", 1);
    // sweep
    for (int i = 0; i < 40; i++) begin
      launch(int'($urandom % 4), {$urandom, $urandom}, $urandom, $urandom, $urandom,
             "R2 sweep", (i % 5) == 0);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (400) @(negedge clk);
    chk(seen == launched, "R8 result count", seen, launched);
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", seen, launched);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule